// File: doc/BRIEF.md
# Start-up Calibration Pulse Generator

This block produces the burst of calibration pulses that a converter's power-up self-calibration consumes. It waits until two power indications, supply-good and reference-good, have come up in the required order (supply first). It also waits for the release input to be high and the disable input to be low. It then emits one active-low, one-clock-wide strobe every fixed number of converter clocks. Each strobe's falling edge launches one unit calibration cycle in the downstream sequencer.

A wide span counter counts the pulse intervals. When it carries out, the pulse gate closes for good, and a done flag is raised and held. If the power indications come up in the wrong order, or both at once, the block latches an ordering fault and never starts. Pulling release low or raising disable during a burst aborts it. Both counters clear on an abort, so the next burst always runs to its full length.

Top module: `calgen_startup`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, cal_pulse_n_o is 1 and busy_o, done_o and order_fault_o are 0.
- R2: The block arms only if supply_good_i rises in a cycle strictly before ref_good_i. If ref_good_i rises first, or both rise in the same cycle, order_fault_o goes to 1 on the next clock, and no pulse is produced and busy_o stays 0.
- R3: order_fault_o stays at 1 until supply_good_i and ref_good_i are both 0. It then clears on the next clock.
- R4: Once armed, a burst starts (busy_o goes to 1) only while release_i is 1 and disable_i is 0. Holding disable_i at 1 keeps busy_o at 0.
- R5: With busy_o counted as rising at cycle 0, cal_pulse_n_o is 0 for exactly one cycle at cycles INTERVAL, 2·INTERVAL, and so on, and is 1 in every other cycle.
- R6: A full burst has exactly 2^SPAN_BITS pulses. done_o rises and busy_o falls at cycle INTERVAL·2^SPAN_BITS, which is the same cycle as the last pulse. No pulse follows.
- R7: done_o holds at 1 through any change of disable_i, as long as release_i and both power indications stay at 1. Dropping release_i clears done_o on the next clock. Raising release_i again then starts a fresh full burst.
- R8: If release_i drops or disable_i rises during a burst, busy_o falls on the next clock and the pulses stop. The next burst again produces the full count at the full spacing.
- R9: If supply_good_i drops during a burst, the burst ends (busy_o is 0 on the next clock). With ref_good_i still high, the ordering fault is then latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Asynchronous block reset, active low |
| supply_good_i | input | 1 | Supply-good indication |
| ref_good_i | input | 1 | Reference-good indication |
| release_i | input | 1 | Run request level; must be high to run |
| disable_i | input | 1 | Chip disable; must be low to run |
| cal_pulse_n_o | output | 1 | Calibration strobe, active low, one clock wide |
| busy_o | output | 1 | Burst in progress |
| done_o | output | 1 | Burst finished, sticky |
| order_fault_o | output | 1 | Power-up order violation latched |

## Verification
The bench targets the same-cycle rise of both power indications. A design that treated the tie as correct ordering would start pulsing instead of raising the fault. It aborts bursts at random points and then counts a complete second burst. Counters that do not clear on abort would show up there as a short count or a shifted first pulse. It checks the exact cycle of the final pulse against done. An off-by-one in the span carry would give one pulse too many or too few, or would raise done one interval late. It also toggles disable while done is set, to catch a done flag that falls away.

// File: rtl/calgen_pkg.sv
package calgen_pkg;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_SUPPLY_OK = 3'd1,
    ST_ARMED     = 3'd2,
    ST_RUN       = 3'd3,
    ST_DONE      = 3'd4,
    ST_FAULT     = 3'd5
  } cal_state_e;

  // total clocks in one complete burst
  function automatic int unsigned burst_clocks(int unsigned interval, int unsigned span_bits);
    return interval * (32'd1 << span_bits);
  endfunction

  // true when a count equals its last value before wrapping
  function automatic logic at_last(logic [31:0] cnt, logic [31:0] limit);
    return cnt == (limit - 32'd1);
  endfunction

endpackage

// File: rtl/calgen_interval_ctr.sv
module calgen_interval_ctr #(
  parameter int unsigned INTERVAL = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  import calgen_pkg::*;
  localparam int unsigned IW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;

  logic [IW-1:0] cnt;

  assign tick = en && at_last(32'(cnt), 32'(INTERVAL));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (!en) cnt <= '0;
    else if (tick) cnt <= '0;
    else          cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/calgen_span_ctr.sv
module calgen_span_ctr #(
  parameter int unsigned SPAN_BITS = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic step,
  output logic carry
);
  logic [SPAN_BITS-1:0] cnt;

  assign carry = en && step && (&cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (!en)   cnt <= '0;
    else if (step)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/calgen_arm_fsm.sv
module calgen_arm_fsm (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   supply_good,
  input  logic                   ref_good,
  input  logic                   release_lvl,
  input  logic                   disable_lvl,
  input  logic                   span_carry,
  output calgen_pkg::cal_state_e state
);
  import calgen_pkg::*;

  cal_state_e nxt;
  logic       go;

  assign go = release_lvl && !disable_lvl;

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE: begin
        if (ref_good)         nxt = ST_FAULT;
        else if (supply_good) nxt = ST_SUPPLY_OK;
      end
      ST_SUPPLY_OK: begin
        if (!supply_good)     nxt = ST_IDLE;
        else if (ref_good)    nxt = ST_ARMED;
      end
      ST_ARMED: begin
        if (!supply_good)     nxt = ST_IDLE;
        else if (!ref_good)   nxt = ST_SUPPLY_OK;
        else if (go)          nxt = ST_RUN;
      end
      ST_RUN: begin
        if (!supply_good)     nxt = ST_IDLE;
        else if (!ref_good)   nxt = ST_SUPPLY_OK;
        else if (!go)         nxt = ST_ARMED;
        else if (span_carry)  nxt = ST_DONE;
      end
      ST_DONE: begin
        if (!supply_good)     nxt = ST_IDLE;
        else if (!ref_good)   nxt = ST_SUPPLY_OK;
        else if (!release_lvl) nxt = ST_ARMED;
      end
      ST_FAULT: begin
        if (!supply_good && !ref_good) nxt = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/calgen_startup.sv
module calgen_startup #(
  parameter int unsigned INTERVAL  = 16,
  parameter int unsigned SPAN_BITS = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_good_i,
  input  logic ref_good_i,
  input  logic release_i,
  input  logic disable_i,
  output logic cal_pulse_n_o,
  output logic busy_o,
  output logic done_o,
  output logic order_fault_o
);
  import calgen_pkg::*;

  cal_state_e state;
  logic       running;
  logic       interval_tick;
  logic       span_carry;
  logic       pulse_n_q;

  assign running = (state == ST_RUN);

  calgen_arm_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .supply_good (supply_good_i),
    .ref_good    (ref_good_i),
    .release_lvl (release_i),
    .disable_lvl (disable_i),
    .span_carry  (span_carry),
    .state       (state)
  );

  calgen_interval_ctr #(.INTERVAL(INTERVAL)) u_intv (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (running),
    .tick  (interval_tick)
  );

  calgen_span_ctr #(.SPAN_BITS(SPAN_BITS)) u_span (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (running),
    .step  (interval_tick),
    .carry (span_carry)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_n_q <= 1'b1;
    else        pulse_n_q <= !interval_tick;
  end

  assign cal_pulse_n_o = pulse_n_q;
  assign busy_o        = running;
  assign done_o        = (state == ST_DONE);
  assign order_fault_o = (state == ST_FAULT);
endmodule

// File: rtl/calgen_startup_chk.sv
module calgen_startup_chk (
  input logic clk,
  input logic rst_n,
  input logic supply_good_i,
  input logic ref_good_i,
  input logic release_i,
  input logic disable_i,
  input logic cal_pulse_n_o,
  input logic busy_o,
  input logic done_o,
  input logic order_fault_o,
  input logic interval_tick,
  input logic span_carry
);
  AST_PULSE_ONE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    !cal_pulse_n_o |=> cal_pulse_n_o);  // R5
  AST_TICK_MAKES_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    interval_tick |=> !cal_pulse_n_o);  // R5
  AST_TICK_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    interval_tick |-> busy_o);  // R4
  AST_FAULT_BLOCKS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    order_fault_o |-> !busy_o && !interval_tick);  // R2
  AST_STATUS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({busy_o, done_o, order_fault_o}));  // R2
  AST_CARRY_ENDS_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    span_carry && supply_good_i && ref_good_i && release_i && !disable_i |=> done_o && !busy_o);  // R6
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && release_i && supply_good_i && ref_good_i |=> done_o);  // R7
  AST_ABORT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && (!release_i || disable_i) |=> !busy_o);  // R8
  AST_SUPPLY_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && !supply_good_i |=> !busy_o);  // R9
  AST_FAULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    order_fault_o && (supply_good_i || ref_good_i) |=> order_fault_o);  // R3
endmodule

bind calgen_startup calgen_startup_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .supply_good_i (supply_good_i),
  .ref_good_i    (ref_good_i),
  .release_i     (release_i),
  .disable_i     (disable_i),
  .cal_pulse_n_o (cal_pulse_n_o),
  .busy_o        (busy_o),
  .done_o        (done_o),
  .order_fault_o (order_fault_o),
  .interval_tick (interval_tick),
  .span_carry    (span_carry)
);

// File: tb/tb_calgen_startup.sv
module tb_calgen_startup;
  localparam int unsigned INTV  = 16;
  localparam int unsigned SBITS = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sup = 1'b0, refg = 1'b0, rel = 1'b0, dis = 1'b0;
  logic pulse_n, busy, done, fault;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  calgen_startup #(.INTERVAL(INTV), .SPAN_BITS(SBITS)) dut (
    .clk(clk), .rst_n(rst_n), .supply_good_i(sup), .ref_good_i(refg),
    .release_i(rel), .disable_i(dis), .cal_pulse_n_o(pulse_n),
    .busy_o(busy), .done_o(done), .order_fault_o(fault)
  );

  function automatic int exp_pulses(int unsigned b);
    return 1 << b;
  endfunction
  function automatic int exp_len(int unsigned iv, int unsigned b);
    return iv * exp_pulses(b);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic wait_busy(string req);
    int t = 0;
    while (!busy && t < 20) begin step(); t++; end
    chk(busy, req, busy, 1);
  endtask

  // caller has just sampled busy=1 (cycle 0); measures a complete burst
  task automatic measure_burst(string req);
    int np = 0, first_done = -1, bad_pos = 0, late = 0;
    for (int s = 1; s <= exp_len(INTV, SBITS) + 24; s++) begin
      step();
      if (!pulse_n) begin
        np++;
        if (s % INTV != 0) bad_pos++;
        if (first_done >= 0) late++;
      end
      if (done && first_done < 0) begin
        first_done = s;
        chk(!pulse_n, "R6 last pulse with done", pulse_n, 0);
        chk(!busy, "R6 busy falls", busy, 0);
      end
    end
    chk(bad_pos == 0, {req, " R5 pulse spacing"}, bad_pos, 0);
    chk(np == exp_pulses(SBITS), {req, " R6 pulse count"}, np, exp_pulses(SBITS));
    chk(first_done == exp_len(INTV, SBITS), {req, " R6 done cycle"}, first_done, exp_len(INTV, SBITS));
    chk(late == 0, "R6 no pulse after done", late, 0);
  endtask

  task automatic power_cycle();
    sup = 0; refg = 0; rel = 0; dis = 0;
    step(3);
  endtask

  task automatic power_up_ordered();
    sup = 1; step(2);
    refg = 1; step(2);
  endtask

  initial begin
    while (cycles < 150000) begin @(posedge clk); cycles++; end
    failures++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=<150000", cycles);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int hi_cnt;
    void'($urandom(32'd2024));
    step(3);
    chk(pulse_n && !busy && !done && !fault, "R1 in reset", {pulse_n, busy, done, fault}, 8);
    rst_n = 1'b1;
    step();
    chk(pulse_n && !busy && !done && !fault, "R1 after reset", {pulse_n, busy, done, fault}, 8);

    // R2: reference before supply
    rel = 1; refg = 1; step(2); sup = 1; step();
    chk(fault, "R2 reversed order fault", fault, 1);
    hi_cnt = 0;
    for (int i = 0; i < 40; i++) begin step(); if (!pulse_n || busy) hi_cnt++; end
    chk(hi_cnt == 0, "R2 reversed no pulses", hi_cnt, 0);
    // R3: fault holds until both drop
    refg = 0; step(3);
    chk(fault, "R3 fault holds with supply", fault, 1);
    sup = 0; step();
    chk(!fault, "R3 fault clears", fault, 0);

    // R2: same-cycle rise is a violation
    sup = 1; refg = 1; step();
    chk(fault && !busy, "R2 tie faults", fault, 1);
    power_cycle();

    // R4: disable holds off, then normal burst
    dis = 1; rel = 1; power_up_ordered();
    step(20);
    chk(!busy && !fault, "R4 disable holds off", busy, 0);
    dis = 0; step();
    chk(busy, "R4 start on enable", busy, 1);
    measure_burst("R5/R6 first");

    // R7: done sticky across disable changes
    for (int i = 0; i < 6; i++) begin dis = $urandom_range(0, 1); step(); end
    chk(done, "R7 done sticky", done, 1);
    dis = 0; rel = 0; step();
    chk(!done, "R7 release clears done", done, 0);
    rel = 1;
    wait_busy("R7 restart");
    measure_burst("R7 rerun");

    // R8: random aborts, then a clean full burst
    for (int k = 0; k < 4; k++) begin
      int a = $urandom_range(1, exp_len(INTV, SBITS) - 1);
      bit use_dis = $urandom_range(0, 1);
      rel = 0; step(); rel = 1;
      wait_busy("R8 start");
      step(a);
      if (use_dis) dis = 1; else rel = 0;
      step();
      chk(!busy, "R8 abort busy", busy, 0);
      step();
      hi_cnt = 0;
      for (int i = 0; i < 30; i++) begin step(); if (!pulse_n) hi_cnt++; end
      chk(hi_cnt == 0, "R8 pulses stop", hi_cnt, 0);
      dis = 0; rel = 1;
      wait_busy("R8 restart");
      measure_burst("R8 after abort");
    end

    // R9: supply loss mid-burst
    rel = 0; step(); rel = 1;
    wait_busy("R9 start");
    step($urandom_range(5, 60));
    sup = 0; step();
    chk(!busy, "R9 supply loss stops", busy, 0);
    step();
    chk(fault, "R9 fault latched", fault, 1);
    power_cycle();
    chk(!fault, "R3 cleared after power off", fault, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule